// File: doc/BRIEF.md
# Configurable-resolution PWM generator

A single PWM channel whose period is built from a selected reference tick. The selected tick is slowed by a step prescaler. The prescaler's length is a non-power-of-two factor (1, 3, 5 or 6) times a power of two (2^0 to 2^7). Each prescaler overflow advances a period counter whose width is chosen between 8 and 15 bits. The output is high while the counter is below the duty value, and a one-clock strobe marks the first counted tick of every period.

Software programs the channel through a small register bus with three words:
- a clock/size word holding the reference select and the resolution select;
- a divider word holding the factor select and the exponent;
- a 15-bit duty word.

All settings are captured into working copies only at a period boundary, so a running period is never cut short or distorted. While the channel is idle, written settings are picked up at once.

Top module: `pwm_hr`

## Requirements
- R1: After reset every register reads 0, `pwm_out` is low and `period_start` stays low.
- R2: Address 0 holds the reference select in bits [2:0] and the resolution select in bits [6:4]. Address 1 holds the exponent M in bits [2:0] and the factor select in bits [6:5]. Address 2 holds the duty. Each reads back the last written field values, and all other bits read 0.
- R3: A duty write above 0x7FFF is stored and read back as 0x7FFF.
- R4: Reference codes 1, 2, 3 and 4 count pulses of `tick_en[0]`, `tick_en[1]`, `tick_en[2]` and `tick_en[3]` respectively. Resolution code r gives 2^(r+8) counter steps. Factor codes 0 to 3 mean 1, 3, 5 and 6. One period lasts 2^(r+8) × factor × 2^M reference ticks.
- R5: The high time per period is min(duty, 2^(r+8) − 1) × factor × 2^M reference ticks.
- R6: A duty of 0 keeps `pwm_out` low for the whole period.
- R7: `period_start` pulses for exactly one clock at the first counted tick of each period.
- R8: While running, settings written during a period take effect only from the next period, and the current period completes with its old settings.
- R9: Reference code 0 (and the unused codes 5 to 7) stops the channel once the current period ends: `pwm_out` stays low and no further `period_start` pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 4 | One single-clock tick enable per reference source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pwm_out | output | 1 | PWM level |
| period_start | output | 1 | One-clock pulse at the start of each period |

## Verification
The bench measures whole periods between strobes across every reference source, every factor, several exponents and resolutions. These measurements would expose a factor table or a shift applied in the wrong place. It drives duties above the active range, which a design that skipped the clamp would turn into a stuck-high or wrapped output. It drives a zero duty, where a counter compare off by one would leak a single high step. It rewrites the duty and the reference in mid-period to show that the running period keeps its old high time and length, and that a disable stops the strobes only after that period ends. A design that loaded settings immediately would change the measured high time or truncate the last period.

// File: rtl/pwm_hr.sv
module pwm_hr #(
  parameter int DW   = 15,
  parameter int NREF = 4,
  parameter int PW   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREF-1:0] tick_en,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [15:0]     wdata,
  output logic [15:0]     rdata,
  output logic            pwm_out,
  output logic            period_start
);
  localparam int MAXD = (1 << DW) - 1;

  logic [2:0]    ref_r, res_r, exp_r;
  logic [1:0]    pdv_r;
  logic [DW-1:0] duty_r;

  logic [2:0]    a_ref, a_res, a_exp;
  logic [1:0]    a_pdv;
  logic [DW-1:0] a_duty;

  logic [PW-1:0] pre_cnt;
  logic [DW-1:0] cnt;
  logic          pwm_q, strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_r <= '0; res_r <= '0; exp_r <= '0; pdv_r <= '0; duty_r <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: begin ref_r <= wdata[2:0]; res_r <= wdata[6:4]; end
        2'd1: begin exp_r <= wdata[2:0]; pdv_r <= wdata[6:5]; end
        2'd2: duty_r <= (wdata > 16'(MAXD)) ? DW'(MAXD) : wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {9'd0, res_r, 1'b0, ref_r};
      2'd1:    rdata = {9'd0, pdv_r, 2'd0, exp_r};
      2'd2:    rdata = 16'(duty_r);
      default: rdata = '0;
    endcase
  end

  logic [2:0] pdv_val;
  always_comb begin
    case (a_pdv)
      2'd0:    pdv_val = 3'd1;
      2'd1:    pdv_val = 3'd3;
      2'd2:    pdv_val = 3'd5;
      default: pdv_val = 3'd6;
    endcase
  end

  logic [7:0]    tk_ext;
  logic          run, tick, step, wrap, load;
  logic [PW-1:0] step_len;
  logic [DW-1:0] top, duty_eff;

  assign tk_ext   = 8'({tick_en, 1'b0});
  assign run      = (a_ref != 3'd0) && (32'(a_ref) <= NREF);
  assign tick     = run && tk_ext[a_ref];
  assign step_len = PW'(pdv_val) << a_exp;
  assign step     = tick && (pre_cnt == step_len - PW'(1));
  assign top      = DW'((17'd256 << a_res) - 17'd1);
  assign wrap     = step && (cnt == top);
  assign load     = !run || wrap;
  assign duty_eff = (a_duty > top) ? top : a_duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ref <= '0; a_res <= '0; a_exp <= '0; a_pdv <= '0; a_duty <= '0;
      pre_cnt <= '0; cnt <= '0; pwm_q <= 1'b0; strobe_q <= 1'b0;
    end else begin
      if (load) begin
        a_ref <= ref_r; a_res <= res_r; a_exp <= exp_r;
        a_pdv <= pdv_r; a_duty <= duty_r;
      end
      if (!run) begin
        pre_cnt <= '0;
        cnt     <= '0;
      end else if (tick) begin
        if (step) begin
          pre_cnt <= '0;
          cnt     <= wrap ? '0 : cnt + DW'(1);
        end else begin
          pre_cnt <= pre_cnt + PW'(1);
        end
      end
      pwm_q    <= run && (cnt < duty_eff);
      strobe_q <= tick && (pre_cnt == '0) && (cnt == '0);
    end
  end

  assign pwm_out      = pwm_q;
  assign period_start = strobe_q;

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_out);

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && a_duty == '0) |=> !pwm_out);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top);

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(a_duty) && $stable(a_res) && $stable(a_ref)));
endmodule

// File: tb/pwm_hr_test.sv
module pwm_hr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_en = 4'd0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        pwm_out, period_start;
  int checks = 0, failures = 0;

  pwm_hr uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
              .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out),
              .period_start(period_start));

  always #2.5 clk = ~clk;

  // code1: every 8 clocks, code2: every 4, code3: every 2, code4: every clock
  initial begin
    logic [2:0] tc = 3'd0;
    forever begin
      @(negedge clk);
      tc = tc + 3'd1;
      tick_en = {1'b1, tc[0] == 1'b0, tc[1:0] == 2'd0, tc == 3'd0};
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  localparam int NV = 6;
  localparam int VREF [NV] = '{4, 4, 3, 2, 1, 4};
  localparam int VRES [NV] = '{0, 1, 0, 0, 0, 3};
  localparam int VPDV [NV] = '{0, 1, 2, 3, 0, 0};
  localparam int VEXP [NV] = '{0, 0, 1, 0, 2, 0};
  localparam int VDUT [NV] = '{100, 600, 0, 255, 64, 3000};
  localparam int XPER [NV] = '{256, 1536, 5120, 6144, 8192, 2048};
  localparam int XHI  [NV] = '{100, 1533, 0, 6120, 2048, 2047};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic wait_strobe();
    @(negedge clk);
    while (!period_start) @(negedge clk);
  endtask

  task automatic measure(output int per, output int hi);
    per = 0; hi = 0;
    do begin
      per++;
      if (pwm_out) hi++;
      @(negedge clk);
    end while (!period_start);
  endtask

  initial begin
    int v, p, h, s;
    repeat (4) @(negedge clk);
    // R1: reset state
    s = 0; h = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
      if (period_start) s++;
    end
    chk("R1 pwm_out during reset", h, 0);
    chk("R1 strobe during reset", s, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 0);
    end

    // R2 / R3: readback and saturation
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R2 clock/size readback", v, 16'h0077);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R2 divider readback", v, 16'h0067);
    wr(2'd2, 16'hFFFF); rd(2'd2, v); chk("R3 duty saturation", v, 16'h7FFF);
    wr(2'd2, 16'h1234); rd(2'd2, v); chk("R2 duty readback", v, 16'h1234);
    wr(2'd0, 16'h0000);

    // R4 / R5 / R6: vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 16'(VDUT[i]));
      wr(2'd1, 16'((VPDV[i] << 5) | VEXP[i]));
      wr(2'd0, 16'((VRES[i] << 4) | VREF[i]));
      wait_strobe();
      wait_strobe();
      measure(p, h);
      chk($sformatf("R4 period vector %0d", i), p, XPER[i]);
      chk($sformatf("%s high vector %0d", (VDUT[i] == 0) ? "R6" : "R5", i), h, XHI[i]);
    end

    // R8: duty change in mid-period
    wr(2'd2, 16'd50);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0004);
    wait_strobe();
    wait_strobe();
    fork
      measure(p, h);
      wr(2'd2, 16'd200);
    join
    chk("R8 period kept", p, 256);
    chk("R8 old duty in current period", h, 50);
    measure(p, h);
    chk("R8 new duty next period", h, 200);

    // R9: disable in mid-period (already on a strobe sample)
    s = 0; h = 0;
    fork
      begin
        for (int i = 0; i < 1000; i++) begin
          if (pwm_out) h++;
          if (period_start && i > 0) s++;
          @(negedge clk);
        end
      end
      wr(2'd0, 16'h0000);
    join
    chk("R9 last period high time", h, 200);
    chk("R9 strobes after disable", s, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule